// File: doc/BRIEF.md
# Interrupt Request Flag Register Bank

This block keeps one pending bit for each of 24 interrupt sources, grouped as three 8-bit registers on a small byte-addressed peripheral bus. A peripheral marks its source pending with a single-cycle request pulse. The CPU side clears a bit automatically by presenting an acknowledge strobe with the flag index. Software can also load a whole register with a byte write, or set or clear one bit without disturbing its neighbours. The full 24-bit pending vector drives a downstream priority and vectoring stage, which lies outside this block.

A byte write that carries a read-modify-write value can erase a request that hardware raised between the read and the write. The single-bit operation changes only its target bit, so it avoids that race. A hardware request that arrives in the same cycle as any clear keeps its flag set. The watchdog source's flag accepts software changes only while the watchdog runs as an interval timer. One source can be left out at build time, and its flag then stays at zero.

Top module: `irq_flag_regs`

## Requirements
- R1: While rst_ni is low, every flag is 0 and pend_o reads 0.
- R2: A pulse on req_i[k] sets flag k on the next clock edge. Flag k is bit k%8 of register k/8 and bit k of pend_o. A 1 means the request is pending.
- R3: An edge with ack_valid_i high clears flag ack_idx_i and no other flag. Index values of 24 and above change nothing.
- R4: A byte write (bus_wr_i) to address BASE_ADDR+r, where r is 0, 1 or 2, loads register r from bus_wdata_i on the next edge.
- R5: A bit operation (bit_op_valid_i) to address BASE_ADDR+r with index bit_idx_i sets the bit when bit_op_set_i is 1 and clears it when bit_op_set_i is 0. No other bit changes. On its target bit, the bit operation overrides a byte write made in the same cycle.
- R6: Flag 0 is the watchdog flag. While wdt_interval_i is low it is 0 after every edge, whatever the inputs. While wdt_interval_i is high it behaves like any other flag.
- R7: With OPT_PRESENT=0, flag 10 (register 1, bit 2) ignores requests and writes and always reads 0.
- R8: Reads are combinational and have no side effects. With rd_word_i=0, address BASE_ADDR+r returns {8'h00, register r}. With rd_word_i=1, address BASE_ADDR returns {register 1, register 0}.
- R9: Byte writes and bit operations to addresses outside BASE_ADDR..BASE_ADDR+2 change no flag. A read of any other address, or a word read of any address other than BASE_ADDR, returns 0.
- R10: When several events reach one flag in the same cycle, a hardware request wins over an acknowledge, and an acknowledge wins over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 24 | Per-source request pulses |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 5 | Index of the flag being acknowledged |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_addr_i | input | 16 | Byte write address |
| bus_wdata_i | input | 8 | Byte write data |
| bit_op_valid_i | input | 1 | Bit operation strobe |
| bit_op_set_i | input | 1 | 1 = set the bit, 0 = clear the bit |
| bit_addr_i | input | 16 | Bit operation address |
| bit_idx_i | input | 3 | Bit position within the register |
| rd_addr_i | input | 16 | Read address |
| rd_word_i | input | 1 | 1 = 16-bit read, 0 = byte read |
| rd_data_o | output | 16 | Read data |
| wdt_interval_i | input | 1 | Watchdog runs in interval-timer mode |
| pend_o | output | 24 | Pending flag vector |

## Verification
The assertions take request, acknowledge and bus strobes to be clean single-cycle levels, sampled at the rising edge. The bit-isolation and idle-stability properties apply only in cycles where no other source of change is active. The bench drives every input away from the active edge and releases each strobe after one edge. It combines events deliberately only in the race cases, so every other cycle stays inside those preconditions. Tests that exercise the watchdog-mode input hold it steady across the edge they examine.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W  = 8;
  localparam int BIDX_W = 3;
  localparam int WORD_W = 16;

  typedef enum logic {
    BIT_CLR = 1'b0,
    BIT_SET = 1'b1
  } bit_op_e;
endpackage

// File: rtl/irq_flag_wdec.sv
module irq_flag_wdec
  import irq_flag_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'hFFE0,
  localparam int NUM_FLAGS = NUM_REGS * REG_W
) (
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic                 bop_i,
  input  logic                 bset_i,
  input  logic [ADDR_W-1:0]    baddr_i,
  input  logic [BIDX_W-1:0]    bidx_i,
  output logic [NUM_FLAGS-1:0] we_o,
  output logic [NUM_FLAGS-1:0] val_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic byte_hit, reg_bop_hit;
    assign byte_hit    = wr_i && (addr_i == ADDR_W'(BASE_ADDR + r));
    assign reg_bop_hit = bop_i && (baddr_i == ADDR_W'(BASE_ADDR + r));
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      logic bit_hit;
      assign bit_hit = reg_bop_hit && (bidx_i == BIDX_W'(b));
      assign we_o[r*REG_W+b]  = byte_hit | bit_hit;
      // bit op overrides the byte write on its own bit
      assign val_o[r*REG_W+b] = bit_hit ? (bit_op_e'(bset_i) == BIT_SET) : wdata_i[b];
    end
  end
endmodule

// File: rtl/irq_flag_adec.sv
module irq_flag_adec #(
  parameter int NUM_FLAGS = 24,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_FLAGS-1:0] clr_o
);
  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_dec
    assign clr_o[k] = ack_i && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic we_i,
  input  logic wval_i,
  input  logic en_i,
  output logic q_o
);
  logic q_d;

  // precedence: hw set > ack clear > sw write; en_i low forces 0
  always_comb begin
    q_d = q_o;
    if (we_i && en_i) q_d = wval_i;
    if (clr_i)        q_d = 1'b0;
    if (set_i)        q_d = 1'b1;
    q_d = q_d & en_i & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/irq_flag_rdmux.sv
module irq_flag_rdmux
  import irq_flag_pkg::*;
#(
  parameter int NUM_REGS  = 3,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'hFFE0,
  localparam int NUM_FLAGS = NUM_REGS * REG_W
) (
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 word_i,
  output logic [WORD_W-1:0]    data_o
);
  always_comb begin
    data_o = '0;
    if (word_i) begin
      if (addr_i == ADDR_W'(BASE_ADDR)) data_o = flags_i[WORD_W-1:0];
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (addr_i == ADDR_W'(BASE_ADDR + r))
          data_o = {{(WORD_W-REG_W){1'b0}}, flags_i[r*REG_W +: REG_W]};
      end
    end
  end
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_flag_pkg::*;
#(
  parameter int NUM_REGS    = 3,
  parameter int ADDR_W      = 16,
  parameter int BASE_ADDR   = 'hFFE0,
  parameter int WDT_BIT     = 0,
  parameter int OPT_BIT     = 10,
  parameter bit OPT_PRESENT = 1'b0,
  localparam int NUM_FLAGS  = NUM_REGS * REG_W,
  localparam int IDX_W      = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] req_i,
  input  logic                 ack_valid_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  input  logic                 bit_op_valid_i,
  input  logic                 bit_op_set_i,
  input  logic [ADDR_W-1:0]    bit_addr_i,
  input  logic [BIDX_W-1:0]    bit_idx_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic                 rd_word_i,
  output logic [WORD_W-1:0]    rd_data_o,
  input  logic                 wdt_interval_i,
  output logic [NUM_FLAGS-1:0] pend_o
);
  logic [NUM_FLAGS-1:0] sw_we, sw_val, ack_clr;

  irq_flag_wdec #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_wdec (
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .bop_i  (bit_op_valid_i),
    .bset_i (bit_op_set_i),
    .baddr_i(bit_addr_i),
    .bidx_i (bit_idx_i),
    .we_o   (sw_we),
    .val_o  (sw_val)
  );

  irq_flag_adec #(
    .NUM_FLAGS(NUM_FLAGS)
  ) u_adec (
    .ack_i(ack_valid_i),
    .idx_i(ack_idx_i),
    .clr_o(ack_clr)
  );

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    localparam bit IMPL = OPT_PRESENT || (k != OPT_BIT);
    logic en;
    if (k == WDT_BIT) begin : g_wdt
      assign en = wdt_interval_i;
    end else begin : g_std
      assign en = 1'b1;
    end
    irq_flag_cell #(
      .IMPL(IMPL)
    ) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (req_i[k]),
      .clr_i (ack_clr[k]),
      .we_i  (sw_we[k]),
      .wval_i(sw_val[k]),
      .en_i  (en),
      .q_o   (pend_o[k])
    );
  end

  irq_flag_rdmux #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_rdmux (
    .flags_i(pend_o),
    .addr_i (rd_addr_i),
    .word_i (rd_word_i),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/irq_flag_regs_chk.sv
module irq_flag_regs_chk #(
  parameter int NUM_REGS    = 3,
  parameter int ADDR_W      = 16,
  parameter int BASE_ADDR   = 'hFFE0,
  parameter int WDT_BIT     = 0,
  parameter int OPT_BIT     = 10,
  parameter bit OPT_PRESENT = 1'b0,
  localparam int NF         = NUM_REGS * 8,
  localparam int IDX_W      = $clog2(NF)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NF-1:0]     req_i,
  input logic              ack_valid_i,
  input logic [IDX_W-1:0]  ack_idx_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bit_op_valid_i,
  input logic [ADDR_W-1:0] bit_addr_i,
  input logic [2:0]        bit_idx_i,
  input logic              wdt_interval_i,
  input logic [NF-1:0]     pend_o
);
  function automatic logic [NF-1:0] impl_mask();
    logic [NF-1:0] m = '1;
    if (!OPT_PRESENT) m[OPT_BIT] = 1'b0;
    return m;
  endfunction

  logic [NF-1:0] req_eff, bop_mask;
  logic          wr_in_range, quiet_ctl;

  always_comb begin
    req_eff = req_i & impl_mask();
    if (!wdt_interval_i) req_eff[WDT_BIT] = 1'b0;
    bop_mask    = '0;
    wr_in_range = 1'b0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (bit_op_valid_i && bit_addr_i == ADDR_W'(BASE_ADDR + r)) bop_mask[r*8 + int'(bit_idx_i)] = 1'b1;
      if (bus_addr_i == ADDR_W'(BASE_ADDR + r)) wr_in_range = 1'b1;
    end
  end

  assign quiet_ctl = !ack_valid_i && (req_i == '0) && wdt_interval_i;

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> (pend_o == '0));

  // R10: request wins over any same-cycle clear
  p_hw_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_eff != '0) |=> ((pend_o & $past(req_eff)) == $past(req_eff)));

  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && (int'(ack_idx_i) < NF) && !req_i[ack_idx_i]) |=> !pend_o[$past(ack_idx_i)]);

  p_bit_isolate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_valid_i && !bus_wr_i && quiet_ctl)
      |=> (((pend_o ^ $past(pend_o)) & ~$past(bop_mask)) == '0));

  p_wdt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_interval_i |=> !pend_o[WDT_BIT]);

  if (!OPT_PRESENT) begin : g_opt
    p_opt_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[OPT_BIT] |=> !pend_o[OPT_BIT]);
  end

  p_idle_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_i && !bit_op_valid_i && quiet_ctl) |=> $stable(pend_o));

  p_oor_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !wr_in_range && !bit_op_valid_i && quiet_ctl) |=> $stable(pend_o));
endmodule

bind irq_flag_regs irq_flag_regs_chk #(
  .NUM_REGS   (NUM_REGS),
  .ADDR_W     (ADDR_W),
  .BASE_ADDR  (BASE_ADDR),
  .WDT_BIT    (WDT_BIT),
  .OPT_BIT    (OPT_BIT),
  .OPT_PRESENT(OPT_PRESENT)
) u_chk (.*);

// File: tb/irq_flag_regs_bench.sv
module irq_flag_regs_bench;
  localparam int NF   = 24;
  localparam int BASE = 'hFFE0;
  localparam int OPT  = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [23:0] req_i;
  logic        ack_valid_i;
  logic [4:0]  ack_idx_i;
  logic        bus_wr_i;
  logic [15:0] bus_addr_i;
  logic [7:0]  bus_wdata_i;
  logic        bit_op_valid_i, bit_op_set_i;
  logic [15:0] bit_addr_i;
  logic [2:0]  bit_idx_i;
  logic [15:0] rd_addr_i;
  logic        rd_word_i;
  logic [15:0] rd_data_o;
  logic        wdt_interval_i;
  logic [23:0] pend_o;

  logic [NF-1:0] model;
  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  irq_flag_regs u_irq_flag_regs (.*);

  function automatic logic [NF-1:0] model_next();
    logic [NF-1:0] n = model;
    for (int k = 0; k < NF; k++) begin
      int r = k / 8;
      int b = k % 8;
      logic sw_ok = (k != 0) || wdt_interval_i;
      if (sw_ok && bus_wr_i && bus_addr_i == 16'(BASE + r)) n[k] = bus_wdata_i[b];
      if (sw_ok && bit_op_valid_i && bit_addr_i == 16'(BASE + r) && bit_idx_i == 3'(b)) n[k] = bit_op_set_i;
      if (ack_valid_i && ack_idx_i == 5'(k)) n[k] = 1'b0;
      if (req_i[k]) n[k] = 1'b1;
      if (k == 0 && !wdt_interval_i) n[k] = 1'b0;
      if (k == OPT) n[k] = 1'b0;
    end
    return n;
  endfunction

  task automatic tick();
    logic [NF-1:0] nxt = model_next();
    @(posedge clk_i);
    #2;
    model = nxt;
    req_i = '0; ack_valid_i = 1'b0; bus_wr_i = 1'b0; bit_op_valid_i = 1'b0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pend(string tag);
    check(tag, 32'(pend_o), 32'(model));
  endtask

  task automatic chk_read(string tag, logic [15:0] a, logic w);
    logic [15:0] e = '0;
    rd_addr_i = a; rd_word_i = w;
    #1;
    if (w) begin
      if (a == 16'(BASE)) e = model[15:0];
    end else begin
      for (int r = 0; r < 3; r++) if (a == 16'(BASE + r)) e = {8'h00, model[r*8 +: 8]};
    end
    check(tag, 32'(rd_data_o), 32'(e));
  endtask

  task automatic byte_wr(logic [15:0] a, logic [7:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
  endtask

  task automatic bit_op(logic [15:0] a, logic [2:0] i, logic s);
    bit_op_valid_i = 1'b1; bit_addr_i = a; bit_idx_i = i; bit_op_set_i = s;
  endtask

  task automatic clear_all();
    for (int r = 0; r < 3; r++) begin
      byte_wr(16'(BASE + r), 8'h00);
      tick();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req_i = '0; ack_valid_i = 1'b0; ack_idx_i = '0;
    bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    bit_op_valid_i = 1'b0; bit_op_set_i = 1'b0; bit_addr_i = '0; bit_idx_i = '0;
    rd_addr_i = 16'(BASE); rd_word_i = 1'b1; wdt_interval_i = 1'b1;
    model = '0;
    repeat (3) @(posedge clk_i);
    #2;
    chk_pend("R1 reset");
    chk_read("R1 reset word read", 16'(BASE), 1'b1);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;

    // R2 / R7: every request line
    for (int k = 0; k < NF; k++) begin
      req_i[k] = 1'b1;
      tick();
      chk_pend(k == OPT ? "R7 opt request" : "R2 request set");
    end
    // R3: acknowledge each index, then out-of-range indices
    for (int k = 0; k < 32; k++) begin
      if (k == 24) begin
        byte_wr(16'(BASE + 2), 8'hA5); tick();
      end
      ack_valid_i = 1'b1; ack_idx_i = 5'(k);
      tick();
      chk_pend(k < NF ? "R3 ack clear" : "R3 ack out of range");
    end

    // R4 / R7 / R8: all byte values in all registers
    for (int r = 0; r < 3; r++) begin
      for (int v = 0; v < 256; v++) begin
        byte_wr(16'(BASE + r), 8'(v));
        tick();
        chk_read("R4 byte write readback", 16'(BASE + r), 1'b0);
      end
    end
    byte_wr(16'(BASE), 8'h5A); tick();
    byte_wr(16'(BASE + 1), 8'hC3); tick();
    chk_read("R8 word read", 16'(BASE), 1'b1);
    chk_read("R8 word read again", 16'(BASE), 1'b1);
    chk_pend("R8 read no side effect");

    // R5: set and clear every bit with a background pattern
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < 8; b++) begin
        byte_wr(16'(BASE + r), 8'h96); tick();
        bit_op(16'(BASE + r), 3'(b), 1'b1); tick();
        chk_pend("R5 bit set");
        bit_op(16'(BASE + r), 3'(b), 1'b0); tick();
        chk_pend("R5 bit clear");
      end
    end
    byte_wr(16'(BASE + 1), 8'h00); bit_op(16'(BASE + 1), 3'd4, 1'b1); tick();
    chk_read("R5 bit op over byte write", 16'(BASE + 1), 1'b0);
    check("R5 bit op over byte write value", 32'(pend_o[15:8]), 32'h10);

    // R6: watchdog flag gating
    clear_all();
    wdt_interval_i = 1'b0;
    byte_wr(16'(BASE), 8'hFF); tick();
    chk_pend("R6 byte write gated");
    check("R6 bit0 stays 0", 32'(pend_o[0]), 32'h0);
    bit_op(16'(BASE), 3'd0, 1'b1); tick();
    chk_pend("R6 bit op gated");
    req_i[0] = 1'b1; tick();
    chk_pend("R6 request gated");
    wdt_interval_i = 1'b1;
    bit_op(16'(BASE), 3'd0, 1'b1); tick();
    check("R6 interval mode bit op", 32'(pend_o[0]), 32'h1);
    wdt_interval_i = 1'b0; tick();
    check("R6 leaving interval mode clears", 32'(pend_o[0]), 32'h0);
    wdt_interval_i = 1'b1; tick();

    // R9: out-of-range accesses
    byte_wr(16'(BASE), 8'h3C); tick();
    byte_wr(16'(BASE - 1), 8'hFF); tick();
    chk_pend("R9 write below range");
    byte_wr(16'(BASE + 3), 8'hFF); tick();
    chk_pend("R9 write above range");
    bit_op(16'(BASE + 3), 3'd1, 1'b1); tick();
    chk_pend("R9 bit op above range");
    bit_op(16'h0000, 3'd2, 1'b0); tick();
    chk_pend("R9 bit op far address");
    chk_read("R9 unmapped byte read", 16'(BASE + 3), 1'b0);
    chk_read("R9 unaligned word read", 16'(BASE + 1), 1'b1);
    chk_read("R9 word read upper reg", 16'(BASE + 2), 1'b1);

    // R10: same-cycle races
    clear_all();
    req_i[5] = 1'b1; bit_op(16'(BASE), 3'd5, 1'b0); tick();
    check("R10 req beats bit clear", 32'(pend_o[5]), 32'h1);
    req_i[12] = 1'b1; ack_valid_i = 1'b1; ack_idx_i = 5'd12; tick();
    check("R10 req beats ack", 32'(pend_o[12]), 32'h1);
    req_i[20] = 1'b1; byte_wr(16'(BASE + 2), 8'h00); tick();
    check("R10 req beats byte write", 32'(pend_o[20]), 32'h1);
    ack_valid_i = 1'b1; ack_idx_i = 5'd13; bit_op(16'(BASE + 1), 3'd5, 1'b1); tick();
    check("R10 ack beats bit set", 32'(pend_o[13]), 32'h0);
    ack_valid_i = 1'b1; ack_idx_i = 5'd12; tick();
    check("R3 plain ack", 32'(pend_o[12]), 32'h0);
    chk_pend("R10 final state");

    summary();
    $finish;
  end
endmodule